// File: doc/BRIEF.md
# Decode-Stage Branch Resolution Controller

This block drives the fetch address of a five-stage pipeline and decides the branches there in decode. The instruction held in the IF/ID latch is decoded every cycle. A zero test on its register operand gives the condition of a conditional branch, and a dedicated adder gives its destination: the sequential address (PC+4) plus a sign-extended word offset. The whole decision is made in decode, so a redirected fetch loses at most one instruction slot.

A two-bit mode input selects how that slot is handled. In hold mode, every branch or jump in decode discards the instruction fetched behind it and refetches the correct path. In speculate-fall-through mode, fetch keeps running sequentially and the wrong-path instruction is discarded only when the branch goes. In one-slot-delay mode, the instruction behind the branch always completes and the redirect takes effect after it. The block owns the fetch address register. It emits a squash request for the IF/ID latch and a one-cycle taken indication for each redirecting branch, which lets penalty cycles be counted.

Top module: `bdec_ctrl`

## Requirements
- R1: While `rst` is high, `fetch_pc_o` loads `RESET_PC` (default 0) at each clock edge. When nothing redirects or holds fetch, `fetch_pc_o` advances by 4 every cycle.
- R2: Conditional branches use these opcodes: 6'h04 branches when the register operand equals zero, and 6'h05 branches when it is non-zero. For a valid taken branch, `br_taken_o` is high in that same decode cycle, and it is low in every other cycle.
- R3: The destination is `id_pc4_i` plus the 16-bit offset, sign-extended and multiplied by 4, computed modulo 2^AW. Negative offsets move backward.
- R4: Opcode 6'h02 is an unconditional jump. It is taken whatever the operand value.
- R5: Mode 1 (speculate fall-through): a taken branch or jump raises `squash_o` and makes the next `fetch_pc_o` equal to the destination. A branch that is not taken raises no squash, and fetch advances by 4.
- R6: Mode 2 (one delay slot): `squash_o` is never raised. A taken branch or jump makes the next `fetch_pc_o` equal to the destination.
- R7: Mode 0 (hold): every valid branch or jump in decode raises `squash_o`. The next `fetch_pc_o` is the destination if taken, and `id_pc4_i` otherwise.
- R8: When `id_valid_i` is low, the block ignores the opcode. `squash_o` and `br_taken_o` stay low, and fetch advances by 4.
- R9: Any opcode other than 6'h02, 6'h04 or 6'h05 has no effect on fetch, squash or the taken indication.
- R10: Mode 3 behaves exactly like mode 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Slot policy: 0/3 hold, 1 speculate fall-through, 2 one delay slot |
| id_valid_i | input | 1 | IF/ID latch holds a live instruction |
| id_opcode_i | input | 6 | Opcode field of the decode instruction |
| id_rs_val_i | input | XLEN (32) | Register operand value for the zero test |
| id_offset_i | input | OFFW (16) | Signed word offset of the branch |
| id_pc4_i | input | AW (32) | Sequential address following the decode instruction |
| fetch_pc_o | output | AW (32) | Current fetch address |
| next_pc_o | output | AW (32) | Fetch address for the next cycle |
| squash_o | output | 1 | Invalidate the IF/ID contents at the next edge |
| br_taken_o | output | 1 | One-cycle pulse for a redirecting branch or jump |

## Verification
Some rules are checked on every cycle by the assertions. Delayed mode never squashes. In speculate mode, squash always coincides with a taken branch. An invalid decode slot never redirects. Every taken branch lands fetch on the computed destination, and a hold on a fall-through branch lands fetch on the decode instruction's PC+4. Other behaviour only the bench's scenarios can show: the zero and non-zero conditions on chosen operand values, negative offsets and address wrap, the equivalence of modes 0 and 3, and the uneventful treatment of unrelated opcodes. A behavioural reference model is compared against every output on every cycle of directed and random streams.

// File: rtl/bdec_pkg.sv
package bdec_pkg;

    localparam int unsigned OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_BR_ZERO    = 6'h04;
    localparam logic [OPC_W-1:0] OPC_BR_NONZERO = 6'h05;
    localparam logic [OPC_W-1:0] OPC_JUMP       = 6'h02;

    typedef enum logic [1:0] {
        POL_HOLD      = 2'd0,
        POL_SPEC_FALL = 2'd1,
        POL_DELAY1    = 2'd2,
        POL_HOLD_ALT  = 2'd3
    } policy_e;

    typedef struct packed {
        logic ctl;     // valid control-transfer instruction in decode
        logic uncond;  // unconditional jump
        logic taken;   // redirect decided
    } br_info_t;

    function automatic logic is_hold_policy(policy_e p);
        return (p == POL_HOLD) || (p == POL_HOLD_ALT);
    endfunction

endpackage

// File: rtl/bdec_classify.sv
module bdec_classify
    import bdec_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic             valid_i,
    input  logic [OPC_W-1:0] opcode_i,
    input  logic [XLEN-1:0]  rs_val_i,
    output br_info_t         info_o
);

    logic is_zero;

    assign is_zero = (rs_val_i == '0);

    always_comb begin
        info_o = '0;
        if (valid_i) begin
            case (opcode_i)
                OPC_BR_ZERO: begin
                    info_o.ctl   = 1'b1;
                    info_o.taken = is_zero;
                end
                OPC_BR_NONZERO: begin
                    info_o.ctl   = 1'b1;
                    info_o.taken = !is_zero;
                end
                OPC_JUMP: begin
                    info_o.ctl    = 1'b1;
                    info_o.uncond = 1'b1;
                    info_o.taken  = 1'b1;
                end
                default: info_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/bdec_target.sv
module bdec_target #(
    parameter int unsigned AW   = 32,
    parameter int unsigned OFFW = 16
) (
    input  logic [AW-1:0]   pc4_i,
    input  logic [OFFW-1:0] offset_i,
    output logic [AW-1:0]   target_o
);

    localparam int unsigned WORD_SHIFT = 2;
    localparam int unsigned EXT_W      = AW - OFFW;

    logic [AW-1:0] off_ext;

    generate
        if (EXT_W > 0) begin : g_ext
            assign off_ext = {{EXT_W{offset_i[OFFW-1]}}, offset_i};
        end else begin : g_trunc
            assign off_ext = offset_i[AW-1:0];
        end
    endgenerate

    assign target_o = pc4_i + (off_ext << WORD_SHIFT);

endmodule

// File: rtl/bdec_policy.sv
module bdec_policy
    import bdec_pkg::*;
(
    input  policy_e  pol_i,
    input  br_info_t info_i,
    output logic     squash_o,
    output logic     hold_o
);

    always_comb begin
        squash_o = 1'b0;
        hold_o   = 1'b0;
        case (pol_i)
            POL_SPEC_FALL: squash_o = info_i.taken;
            POL_DELAY1:    squash_o = 1'b0;
            default: begin
                squash_o = info_i.ctl;
                hold_o   = info_i.ctl && !info_i.taken;
            end
        endcase
    end

endmodule

// File: rtl/bdec_ctrl.sv
module bdec_ctrl
    import bdec_pkg::*;
#(
    parameter int unsigned      AW       = 32,
    parameter int unsigned      XLEN     = 32,
    parameter int unsigned      OFFW     = 16,
    parameter logic [AW-1:0]    RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_i,
    input  logic             id_valid_i,
    input  logic [5:0]       id_opcode_i,
    input  logic [XLEN-1:0]  id_rs_val_i,
    input  logic [OFFW-1:0]  id_offset_i,
    input  logic [AW-1:0]    id_pc4_i,
    output logic [AW-1:0]    fetch_pc_o,
    output logic [AW-1:0]    next_pc_o,
    output logic             squash_o,
    output logic             br_taken_o
);

    localparam logic [AW-1:0] SEQ_STEP = AW'(4);

    policy_e       pol;
    br_info_t      info;
    logic [AW-1:0] target;
    logic          hold;
    logic [AW-1:0] pc_q;

    assign pol = policy_e'(mode_i);

    bdec_classify #(.XLEN(XLEN)) u_classify (
        .valid_i  (id_valid_i),
        .opcode_i (id_opcode_i),
        .rs_val_i (id_rs_val_i),
        .info_o   (info)
    );

    bdec_target #(.AW(AW), .OFFW(OFFW)) u_target (
        .pc4_i    (id_pc4_i),
        .offset_i (id_offset_i),
        .target_o (target)
    );

    bdec_policy u_policy (
        .pol_i    (pol),
        .info_i   (info),
        .squash_o (squash_o),
        .hold_o   (hold)
    );

    always_comb begin
        if (info.taken)  next_pc_o = target;
        else if (hold)   next_pc_o = id_pc4_i;
        else             next_pc_o = pc_q + SEQ_STEP;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= RESET_PC;
        else     pc_q <= next_pc_o;
    end

    assign fetch_pc_o = pc_q;
    assign br_taken_o = info.taken;

    // Delay-slot mode keeps the following instruction alive
    assert_delay_no_squash_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'd2) |-> !squash_o);

    // Speculation discards exactly when the branch goes
    assert_spec_squash_taken_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'd1) |-> (squash_o == br_taken_o));

    // An empty decode slot causes nothing
    assert_invalid_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !id_valid_i |-> (!squash_o && !br_taken_o));

    // A taken branch lands fetch on pc4 + offset*4
    assert_taken_lands_R3: assert property (@(posedge clk) disable iff (rst)
        br_taken_o |=> (fetch_pc_o == $past(id_pc4_i
            + (AW'($signed(id_offset_i)) << 2))));

    // Hold mode refetches the fall-through address of an untaken branch
    assert_hold_fallthrough_R7: assert property (@(posedge clk) disable iff (rst)
        (squash_o && !br_taken_o) |=> (fetch_pc_o == $past(id_pc4_i)));

    // No event: sequential fetch
    assert_sequential_R1: assert property (@(posedge clk) disable iff (rst)
        (!squash_o && !br_taken_o) |=> (fetch_pc_o == $past(fetch_pc_o) + SEQ_STEP));

endmodule

// File: tb/bdec_ctrl_tb.sv
module bdec_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  mode;
    logic        vld;
    logic [5:0]  opc;
    logic [31:0] rsv;
    logic [15:0] off;
    logic [31:0] pc4;
    logic [31:0] fetch_pc, next_pc;
    logic        squash, taken;

    int checks = 0;
    int errors = 0;
    logic [31:0] model_pc;

    always #(CLK_PERIOD/2) clk = ~clk;

    bdec_ctrl dut_i (
        .clk(clk), .rst(rst), .mode_i(mode), .id_valid_i(vld),
        .id_opcode_i(opc), .id_rs_val_i(rsv), .id_offset_i(off),
        .id_pc4_i(pc4), .fetch_pc_o(fetch_pc), .next_pc_o(next_pc),
        .squash_o(squash), .br_taken_o(taken)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string tag_for(input logic [1:0] m, input logic v,
                                      input logic [5:0] o);
        if (!v) return "R8";
        if (o != 6'h02 && o != 6'h04 && o != 6'h05) return "R9";
        case (m)
            2'd0: return "R7";
            2'd1: return "R5";
            2'd2: return "R6";
            default: return "R10";
        endcase
    endfunction

    // Apply one decode cycle, compare against the reference, advance a clock
    task automatic step(input logic [1:0] m, input logic v, input logic [5:0] o,
                        input logic [31:0] r, input logic [15:0] f,
                        input logic [31:0] p4, input string extra);
        int          ctl, tk, sq;
        logic [31:0] dest, nxt;
        string       t;
        mode = m; vld = v; opc = o; rsv = r; off = f; pc4 = p4;
        #1;
        ctl = 0; tk = 0;
        if (v) begin
            if (o == 6'h04) begin ctl = 1; tk = (r == 0) ? 1 : 0; end
            if (o == 6'h05) begin ctl = 1; tk = (r != 0) ? 1 : 0; end
            if (o == 6'h02) begin ctl = 1; tk = 1; end
        end
        dest = p4 + 32'(int'($signed(f)) * 4);
        if (m == 2'd1)      sq = tk;
        else if (m == 2'd2) sq = 0;
        else                sq = ctl;
        if (tk != 0)                              nxt = dest;
        else if ((m == 2'd0 || m == 2'd3) && ctl != 0) nxt = p4;
        else                                      nxt = model_pc + 32'd4;
        t = (extra != "") ? extra : tag_for(m, v, o);
        check("R2", "br_taken", {31'b0, taken}, 32'(tk));
        check(t, "squash", {31'b0, squash}, 32'(sq));
        check(t, "next_pc", next_pc, nxt);
        model_pc = nxt;
        @(posedge clk);
        @(negedge clk);
        check(t, "fetch_pc", fetch_pc, model_pc);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; mode = 2'd0; vld = 1'b0; opc = '0; rsv = '0; off = '0; pc4 = '0;
        @(negedge clk);
        @(negedge clk);
        check("R1", "reset fetch_pc", fetch_pc, 32'h0);
        rst = 1'b0;
        model_pc = 32'h0;

        // R1 / R8: sequential fetch with empty decode slot
        step(2'd1, 1'b0, 6'h04, 32'h0, 16'h0010, 32'h100, "R8");
        step(2'd1, 1'b0, 6'h00, 32'h1, 16'h0000, 32'h100, "R1");
        // R9: unrelated opcode, valid
        step(2'd0, 1'b1, 6'h23, 32'h0, 16'h0040, 32'h200, "R9");
        // R2/R5: zero-branch taken, speculate mode
        step(2'd1, 1'b1, 6'h04, 32'h0, 16'h0008, 32'h1000, "R5");
        // R2/R5: zero-branch not taken
        step(2'd1, 1'b1, 6'h04, 32'h5, 16'h0008, 32'h1000, "R5");
        // R2: non-zero branch taken and not taken
        step(2'd1, 1'b1, 6'h05, 32'h80000000, 16'h0003, 32'h2000, "R2");
        step(2'd1, 1'b1, 6'h05, 32'h0, 16'h0003, 32'h2000, "R2");
        // R3: negative offset and wrap-around
        step(2'd1, 1'b1, 6'h05, 32'h1, 16'hFFFC, 32'h3000, "R3");
        step(2'd2, 1'b1, 6'h02, 32'h0, 16'hFFFF, 32'h00000000, "R3");
        step(2'd2, 1'b1, 6'h02, 32'h0, 16'h7FFF, 32'hFFFFFFF0, "R3");
        // R4: jump with non-zero and zero operands
        step(2'd1, 1'b1, 6'h02, 32'hDEAD, 16'h0020, 32'h400, "R4");
        step(2'd0, 1'b1, 6'h02, 32'h0, 16'h0020, 32'h400, "R4");
        // R6: delay mode, taken and not taken
        step(2'd2, 1'b1, 6'h04, 32'h0, 16'h0100, 32'h500, "R6");
        step(2'd2, 1'b1, 6'h04, 32'h7, 16'h0100, 32'h500, "R6");
        // R7: hold mode, not-taken refetch and taken
        step(2'd0, 1'b1, 6'h05, 32'h0, 16'h0010, 32'h604, "R7");
        step(2'd0, 1'b1, 6'h05, 32'h9, 16'h0010, 32'h604, "R7");
        // R10: mode 3 mirrors mode 0
        step(2'd3, 1'b1, 6'h04, 32'h3, 16'h0010, 32'h704, "R10");
        step(2'd3, 1'b1, 6'h04, 32'h0, 16'h0010, 32'h704, "R10");
        step(2'd3, 1'b0, 6'h02, 32'h0, 16'h0010, 32'h704, "R10");

        // Random stream across all modes
        for (int i = 0; i < 400; i++) begin
            logic [5:0] o;
            case ($urandom_range(0, 3))
                0: o = 6'h04;
                1: o = 6'h05;
                2: o = 6'h02;
                default: o = 6'($urandom);
            endcase
            step(2'($urandom), ($urandom_range(0, 3) != 0),
                 o, ($urandom_range(0, 1) != 0) ? 32'h0 : 32'($urandom),
                 16'($urandom), model_pc, "");
        end

        // R1: reset mid-stream returns fetch to zero
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", "re-reset fetch_pc", fetch_pc, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule